// File: doc/BRIEF.md
# Device Configuration Sequencer

This block is the control state machine that walks a programmable logic device from the moment its supplies come up to the moment its user logic runs. It waits until both the core and the I/O supplies are reported good, clears configuration memory for a fixed number of cycles, and lets any external agent stretch that clearing by holding the shared ready/error line or the reset-request pin low. When the line rises, it latches the mode inputs and starts accepting configuration frames.

The frame path and the check computation are reduced to a handshake. A frame is offered with `frame_valid`. The frame marked `frame_last` carries the embedded check value on `frame_data`, and that value is compared with `calc_chk`. A match starts a three-step start-up: done rises first, then the I/O enable, then the global-reset release. A mismatch parks the sequencer in an error state with the shared line pulled low.

The shared line is open-drain. The block only ever pulls it low (`rdy_pull_low`) or lets it go, and it reads back the resolved wired-AND level on `rdy_line`.

Top module: `cfg_sequencer`

## Requirements
- R1: Until both `pwr_core_ok` and `pwr_io_ok` are high, `rdy_pull_low` is 1 and `frame_ready`, `done`, `io_enable` and `gsr_release` are 0. Losing either supply in any state gives this condition again in the next cycle.
- R2: After power becomes good, or after `prog_req_n` returns high, `rdy_pull_low` stays 1 for exactly CLEAR_CYCLES cycles and is then released.
- R3: While `prog_req_n` is held low, the clear phase does not advance. `rdy_pull_low` stays 1 and `frame_ready` stays 0 however long the hold lasts.
- R4: After the clear phase, the sequencer waits with its pull released while `rdy_line` is observed low from outside. It moves on to loading one cycle after `rdy_line` is seen high.
- R5: `mode_q` takes the value of `mode_in` in the cycle the ready line is first seen high after clearing. It then stays unchanged until the next configuration attempt.
- R6: `frame_ready` is 1 only in the load phase. A frame offered before then, including a frame marked last with a wrong check value, has no effect.
- R7: When the last frame's `frame_data` equals `calc_chk`, the following happens on successive cycles: `done` rises in the next cycle, `io_enable` one cycle later, and `gsr_release` one cycle after that. All three then stay high.
- R8: When the last frame's `frame_data` differs from `calc_chk`, `rdy_pull_low` becomes 1 and `frame_ready` becomes 0 in the next cycle, and `done` stays 0. This holds, and further frames are ignored, until `prog_req_n` goes low or a supply is lost.
- R9: `prog_req_n` low at any time, including during user operation, gives `rdy_pull_low` = 1 and `done`, `io_enable`, `gsr_release` = 0 in the next cycle, and restarts the clear phase.
- R10: After a synchronous reset (`rst_n` low), `rdy_pull_low` is 1 and all other control outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_core_ok | input | 1 | Core supply good |
| pwr_io_ok | input | 1 | I/O supply good |
| prog_req_n | input | 1 | Reset request, active low |
| rdy_line | input | 1 | Resolved level of the shared open-drain ready/error line |
| mode_in | input | MODE_W | Mode selection inputs |
| frame_valid | input | 1 | A configuration frame is offered |
| frame_last | input | 1 | Offered frame is the final one |
| frame_data | input | CHK_W | Embedded check value on the last frame |
| calc_chk | input | CHK_W | Internally computed check value |
| rdy_pull_low | output | 1 | Pull the shared line low (1) or release it (0) |
| frame_ready | output | 1 | Frames are accepted |
| mode_q | output | MODE_W | Captured mode |
| done | output | 1 | Configuration done flag |
| io_enable | output | 1 | User I/O enable |
| gsr_release | output | 1 | Global reset net released |

## Verification
The bench builds the block with CLEAR_CYCLES = 5, MODE_W = 3 and CHK_W = 8. A clear phase of five cycles is short enough that its exact length can be counted edge by edge and still leaves room for an external hold of several cycles. The 3-bit mode and 8-bit check values make it possible to pick distinct mode codes and to choose check pairs that differ in a single bit or are all zeros. The same values also leave room for frame counts from one up to six.

// File: rtl/cfgseq_pkg.sv
// Shared types for the configuration sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package cfgseq_pkg;

    // Phases of the configuration flow.
    typedef enum logic [2:0] {
        ST_PWR   = 3'd0,
        ST_CLEAR = 3'd1,
        ST_REL   = 3'd2,
        ST_LOAD  = 3'd3,
        ST_START = 3'd4,
        ST_USER  = 3'd5,
        ST_ERR   = 3'd6
    } cfg_state_e;

    // Number of start-up steps: done, then I/O enable, then reset release.
    localparam int START_STEPS = 3;

endpackage

// File: rtl/cfgseq_step_cnt.sv
// Phase step counter, shared by the clear and start-up phases.
// Assumes: clr has priority over en; the count wraps if left enabled.
module cfgseq_step_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);

    // Count enabled cycles, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (en)       cnt <= cnt + W'(1);
    end

endmodule

// File: rtl/cfgseq_chk_cmp.sv
// Compares the embedded check value with the computed one.
// Assumes: both operands are valid in the same cycle.
module cfgseq_chk_cmp #(
    parameter int CHK_W = 16
) (
    input  logic [CHK_W-1:0] embedded,
    input  logic [CHK_W-1:0] computed,
    output logic             match
);

    logic [CHK_W-1:0] bit_diff;

    // One difference flag per bit.
    for (genvar g = 0; g < CHK_W; g++) begin : g_bit
        assign bit_diff[g] = embedded[g] ^ computed[g];
    end

    // Equal when no bit differs.
    assign match = ~|bit_diff;

endmodule

// File: rtl/cfgseq_mode_latch.sv
// Holds the mode inputs captured at the ready-line rising moment.
// Assumes: cap is a single-cycle strobe from the sequencer.
module cfgseq_mode_latch #(
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [MODE_W-1:0] d,
    output logic [MODE_W-1:0] q
);

    // Capture on strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (cap) q <= d;
    end

endmodule

// File: rtl/cfg_sequencer.sv
// Configuration sequencer: supply wait, memory clear with external
// stretching, mode capture, frame load, check compare, then either start-up
// or abort.
// Assumes: rdy_line is the wired-AND of rdy_pull_low and all other drivers;
// all inputs are synchronous to clk.
module cfg_sequencer
    import cfgseq_pkg::*;
#(
    parameter int CLEAR_CYCLES = 64,
    parameter int MODE_W       = 3,
    parameter int CHK_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_core_ok,
    input  logic              pwr_io_ok,
    input  logic              prog_req_n,
    input  logic              rdy_line,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              frame_valid,
    input  logic              frame_last,
    input  logic [CHK_W-1:0]  frame_data,
    input  logic [CHK_W-1:0]  calc_chk,
    output logic              rdy_pull_low,
    output logic              frame_ready,
    output logic [MODE_W-1:0] mode_q,
    output logic              done,
    output logic              io_enable,
    output logic              gsr_release
);

    localparam int MAX_STEPS = (CLEAR_CYCLES > START_STEPS) ? CLEAR_CYCLES : START_STEPS;
    localparam int CNT_W     = $clog2(MAX_STEPS + 1);
    localparam logic [CNT_W-1:0] CLEAR_LAST = CNT_W'(CLEAR_CYCLES - 1);
    localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_STEPS - 1);

    cfg_state_e       state_q, state_d;
    logic [CNT_W-1:0] step;
    logic             pwr_ok, chk_match, last_taken, mode_cap;

    assign pwr_ok     = pwr_core_ok & pwr_io_ok;
    assign last_taken = (state_q == ST_LOAD) && frame_valid && frame_last;
    assign mode_cap   = pwr_ok && prog_req_n && (state_q == ST_REL) && rdy_line;

    cfgseq_chk_cmp #(.CHK_W(CHK_W)) u_cmp (
        .embedded (frame_data),
        .computed (calc_chk),
        .match    (chk_match)
    );

    cfgseq_step_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((state_d != state_q) || !prog_req_n),
        .en    ((state_q == ST_CLEAR) || (state_q == ST_START)),
        .cnt   (step)
    );

    cfgseq_mode_latch #(.MODE_W(MODE_W)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (mode_cap),
        .d     (mode_in),
        .q     (mode_q)
    );

    // Next phase: supply loss and reset request override every phase.
    always_comb begin
        state_d = state_q;
        if (!pwr_ok) begin
            state_d = ST_PWR;
        end else if (!prog_req_n) begin
            state_d = ST_CLEAR;
        end else begin
            unique case (state_q)
                ST_PWR:   state_d = ST_CLEAR;
                ST_CLEAR: if (step == CLEAR_LAST) state_d = ST_REL;
                ST_REL:   if (rdy_line) state_d = ST_LOAD;
                ST_LOAD:  if (last_taken) state_d = chk_match ? ST_START : ST_ERR;
                ST_START: if (step == START_LAST) state_d = ST_USER;
                ST_USER:  state_d = ST_USER;
                ST_ERR:   state_d = ST_ERR;
                default:  state_d = ST_PWR;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PWR;
        else        state_q <= state_d;
    end

    // Output decode from the phase and the start-up step.
    always_comb begin
        rdy_pull_low = (state_q == ST_PWR) || (state_q == ST_CLEAR) || (state_q == ST_ERR);
        frame_ready  = (state_q == ST_LOAD);
        done         = (state_q == ST_START) || (state_q == ST_USER);
        io_enable    = ((state_q == ST_START) && (step >= CNT_W'(1))) || (state_q == ST_USER);
        gsr_release  = ((state_q == ST_START) && (step >= CNT_W'(2))) || (state_q == ST_USER);
    end

endmodule

// File: rtl/cfg_sequencer_chk.sv
// Checker for the configuration sequencer, bound to every instance.
// Assumes: observes top-level ports only.
module cfg_sequencer_chk #(
    parameter int MODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_core_ok,
    input logic              pwr_io_ok,
    input logic              prog_req_n,
    input logic              rdy_line,
    input logic              rdy_pull_low,
    input logic              frame_ready,
    input logic [MODE_W-1:0] mode_q,
    input logic              done,
    input logic              io_enable,
    input logic              gsr_release
);

    AST_PWR_LOSS_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_core_ok || !pwr_io_ok) |=> (rdy_pull_low && !done && !frame_ready)); // R1

    AST_PROG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_req_n |=> (rdy_pull_low && !done && !io_enable && !gsr_release)); // R9

    AST_LOAD_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_ready) |-> $past(rdy_line)); // R4

    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ready && $past(frame_ready)) |-> $stable(mode_q)); // R5

    AST_IO_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_enable) |-> (done && $past(done))); // R7

    AST_GSR_AFTER_IO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gsr_release) |-> (io_enable && $past(io_enable))); // R7

    AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_ready && $past(frame_ready) && rdy_pull_low &&
         $past(prog_req_n) && $past(pwr_core_ok) && $past(pwr_io_ok)) |=> rdy_pull_low); // R8

    AST_READY_ONLY_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ready |-> !rdy_pull_low); // R6

endmodule

bind cfg_sequencer cfg_sequencer_chk #(.MODE_W(MODE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_core_ok  (pwr_core_ok),
    .pwr_io_ok    (pwr_io_ok),
    .prog_req_n   (prog_req_n),
    .rdy_line     (rdy_line),
    .rdy_pull_low (rdy_pull_low),
    .frame_ready  (frame_ready),
    .mode_q       (mode_q),
    .done         (done),
    .io_enable    (io_enable),
    .gsr_release  (gsr_release)
);

// File: tb/test_cfg_sequencer.sv
// Self-checking bench: a vector table of load outcomes, then directed tests.
module test_cfg_sequencer;

    localparam int CLR    = 5;
    localparam int MODE_W = 3;
    localparam int CHK_W  = 8;
    localparam int NVEC   = 6;
    // Layout: {embedded[20:13], computed[12:5], frames[4:1], expect_pass[0]}
    localparam logic [20:0] VEC [NVEC] = '{
        {8'hA5, 8'hA5, 4'd1, 1'b1},
        {8'h3C, 8'h3D, 4'd3, 1'b0},
        {8'h00, 8'h00, 4'd4, 1'b1},
        {8'hFF, 8'h7F, 4'd2, 1'b0},
        {8'h81, 8'h81, 4'd6, 1'b1},
        {8'h10, 8'h01, 4'd1, 1'b0}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic pwr_core_ok = 0, pwr_io_ok = 0, prog_req_n = 1, ext_hold = 0;
    logic [MODE_W-1:0] mode_in = '0;
    logic frame_valid = 0, frame_last = 0;
    logic [CHK_W-1:0] frame_data = '0, calc_chk = '0;
    logic rdy_line, rdy_pull_low, frame_ready, done, io_enable, gsr_release;
    logic [MODE_W-1:0] mode_q;
    int nchk = 0, nfail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    // Open-drain resolution of the shared line.
    assign rdy_line = !(rdy_pull_low || ext_hold);

    cfg_sequencer #(.CLEAR_CYCLES(CLR), .MODE_W(MODE_W), .CHK_W(CHK_W)) i_cfg_sequencer (
        .clk(clk), .rst_n(rst_n), .pwr_core_ok(pwr_core_ok), .pwr_io_ok(pwr_io_ok),
        .prog_req_n(prog_req_n), .rdy_line(rdy_line), .mode_in(mode_in),
        .frame_valid(frame_valid), .frame_last(frame_last), .frame_data(frame_data),
        .calc_chk(calc_chk), .rdy_pull_low(rdy_pull_low), .frame_ready(frame_ready),
        .mode_q(mode_q), .done(done), .io_enable(io_enable), .gsr_release(gsr_release)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Pulse the reset request and run to the load phase.
    task automatic to_load(input logic [MODE_W-1:0] m);
        mode_in = m;
        prog_req_n = 0; step(1);
        prog_req_n = 1; step(CLR + 1);
        chk("R4 load entered", int'(frame_ready), 1);
    endtask

    // Offer n frames, the last one carrying the embedded check value.
    task automatic send(input int n, input logic [CHK_W-1:0] emb, input logic [CHK_W-1:0] calc);
        for (int k = 0; k < n - 1; k++) begin
            frame_valid = 1; frame_last = 0; step(1);
            chk("R6 ready while loading", int'(frame_ready), 1);
        end
        frame_valid = 1; frame_last = 1; frame_data = emb; calc_chk = calc;
        step(1);
        frame_valid = 0; frame_last = 0;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            nfail++; nchk++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        step(3);
        // R10 reset state
        chk("R10 pull", int'(rdy_pull_low), 1);
        chk("R10 done", int'(done), 0);
        chk("R10 ready", int'(frame_ready), 0);
        chk("R10 io", int'(io_enable), 0);
        chk("R10 gsr", int'(gsr_release), 0);
        rst_n = 1;
        // R1: one supply only
        pwr_core_ok = 1; step(10);
        chk("R1 one supply pull", int'(rdy_pull_low), 1);
        chk("R1 one supply ready", int'(frame_ready), 0);
        // R2: clear length after power good
        pwr_io_ok = 1; step(CLR);
        chk("R2 still clearing", int'(rdy_pull_low), 1);
        step(1);
        chk("R2 released", int'(rdy_pull_low), 0);
        step(1);
        chk("R4 load after release", int'(frame_ready), 1);

        // Vector table: load outcomes.
        for (int v = 0; v < NVEC; v++) begin
            to_load(MODE_W'(v));
            send(int'(VEC[v][4:1]), VEC[v][20:13], VEC[v][12:5]);
            if (VEC[v][0]) begin
                chk("R7 done", int'(done), 1);
                chk("R7 io later", int'(io_enable), 0);
                step(1);
                chk("R7 io", int'(io_enable), 1);
                chk("R7 gsr later", int'(gsr_release), 0);
                step(1);
                chk("R7 gsr", int'(gsr_release), 1);
                step(2);
                chk("R7 user", int'(done & io_enable & gsr_release), 1);
            end else begin
                chk("R8 pull", int'(rdy_pull_low), 1);
                chk("R8 done", int'(done), 0);
                chk("R8 ready", int'(frame_ready), 0);
            end
            chk("R5 mode", int'(mode_q), v);
        end

        // R8: error persists, frames ignored, reset request recovers.
        to_load(3'd1);
        send(1, 8'h44, 8'h45);
        step(20);
        frame_valid = 1; frame_last = 1; frame_data = 8'h12; calc_chk = 8'h12;
        step(2);
        frame_valid = 0; frame_last = 0;
        chk("R8 sticky pull", int'(rdy_pull_low), 1);
        chk("R8 sticky done", int'(done), 0);
        to_load(3'd1);

        // R3: long reset request hold.
        prog_req_n = 0; step(CLR + 7);
        chk("R3 held pull", int'(rdy_pull_low), 1);
        chk("R3 held ready", int'(frame_ready), 0);
        prog_req_n = 1; step(CLR - 1);
        chk("R3 clear after hold", int'(rdy_pull_low), 1);
        step(1);
        chk("R3 release after hold", int'(rdy_pull_low), 0);
        step(1);

        // R4/R5: external hold of the line, mode at rising moment.
        ext_hold = 1; mode_in = 3'd2;
        prog_req_n = 0; step(1); prog_req_n = 1; step(CLR + 6);
        chk("R4 waiting pull", int'(rdy_pull_low), 0);
        chk("R4 waiting ready", int'(frame_ready), 0);
        mode_in = 3'd5; ext_hold = 0; step(1);
        chk("R4 load after hold", int'(frame_ready), 1);
        chk("R5 captured", int'(mode_q), 5);
        mode_in = 3'd6; step(3);
        chk("R5 stable", int'(mode_q), 5);

        // R6: last frame with bad check offered during clearing is ignored.
        prog_req_n = 0; step(1); prog_req_n = 1;
        frame_valid = 1; frame_last = 1; frame_data = 8'h11; calc_chk = 8'h22;
        step(1);
        chk("R6 not ready in clear", int'(frame_ready), 0);
        step(CLR - 2);
        frame_valid = 0; frame_last = 0;
        step(2);
        chk("R6 load not error", int'(frame_ready), 1);
        chk("R6 line released", int'(rdy_pull_low), 0);
        send(1, 8'h5A, 8'h5A);
        step(3);
        chk("R6 then user", int'(gsr_release), 1);

        // R9: reset request during user operation.
        prog_req_n = 0; step(1);
        chk("R9 pull", int'(rdy_pull_low), 1);
        chk("R9 done", int'(done), 0);
        chk("R9 io", int'(io_enable), 0);
        chk("R9 gsr", int'(gsr_release), 0);
        prog_req_n = 1;

        // R1: supply loss during user operation.
        step(CLR + 1);
        send(1, 8'h33, 8'h33);
        step(3);
        chk("R1 user before loss", int'(done), 1);
        pwr_io_ok = 0; step(1);
        chk("R1 loss done", int'(done), 0);
        chk("R1 loss io", int'(io_enable), 0);
        chk("R1 loss pull", int'(rdy_pull_low), 1);
        step(10);
        chk("R1 loss ready", int'(frame_ready), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule